// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the interrupt status and enable state for a 16-bit timer/counter that has three output compare channels (A, B, C), one input capture channel and an overflow event. The timer core sends it single-cycle event indications: a counter-equals-compare signal for each compare channel, a forced-compare strobe for each channel, a capture edge, a counter-at-TOP indication with a selector for whether the capture register is the TOP source, and an overflow. It also sends a timer tick that marks the system clock cycles on which the timer advances. The block samples events only on ticked cycles. Each qualified event raises a sticky flag. An interrupt request goes out for each source whose flag and enable are both set while the global enable is on.

Software reaches the block through a single-cycle register bus. One address bit selects the flag register or the mask register. Writing a one to a flag bit clears that flag. The interrupt controller can also clear a flag by pulsing the acknowledge line for its source. When a hardware set lands in the same cycle as a clear, the set takes priority.

Each compare channel has a two-state machine that delays its flag by one timer tick. In CMP_IDLE, a ticked match without a force strobe takes the *arm* transition to CMP_ARMED. A ticked cycle without such a match stays in CMP_IDLE (*idle*). In CMP_ARMED, a cycle without a tick takes *wait* and stays put. On the next tick the state *fires* and sets the flag. At that point it takes *rearm* (stays in CMP_ARMED) if a fresh unforced match is present, and otherwise takes *disarm* back to CMP_IDLE.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset, the flag register, the mask register and every interrupt request read zero.
- R2: An overflow sets flag bit 0 on the clock edge that samples it, but only when the tick is high in that cycle. An overflow without a tick changes nothing.
- R3: A compare match for channel A, B or C (flag bits 1, 2, 3) sampled on a tick sets its flag on the clock edge of the next ticked cycle, not earlier.
- R4: A forced-compare strobe never sets a compare flag. A match that arrives together with a force strobe on the same channel is discarded.
- R5: With the capture-is-TOP selector low, a ticked capture edge sets flag bit 5 and counter-at-TOP is ignored. With the selector high, a ticked counter-at-TOP sets bit 5 and capture edges are ignored.
- R6: A bus write to address 0 clears every flag whose data bit is one and leaves the flags whose data bit is zero unchanged.
- R7: Acknowledge bit i clears the flag of source i on the next edge. Source order: 0 overflow, 1 compare A, 2 compare B, 3 compare C, 4 capture.
- R8: Interrupt request i is high exactly when the flag of source i, its enable bit in the mask register (same bit positions as the flags), and the global enable are all one. Request order is the same as acknowledge order.
- R9: Bits 7, 6 and 4 of both registers always read zero, and writes to them have no effect.
- R10: When a hardware set and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R11: Reads return the flag register at address 0 and the mask register at address 1, combinationally. A write to address 1 loads the mask on the next clock edge without touching the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable; events are sampled only while it is high |
| cmp_eq | input | 3 | Counter equals compare register, channels A(0), B(1), C(2) |
| cmp_force | input | 3 | Forced-compare strobes, same channel order |
| cap_edge | input | 1 | Capture edge detected on the capture pin |
| cnt_at_top | input | 1 | Counter has reached TOP |
| cap_is_top | input | 1 | Capture register is the TOP source in the current mode |
| ovf | input | 1 | Counter overflow |
| gie | input | 1 | Global interrupt enable |
| ack | input | 5 | Vector acknowledge per source |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 flags, 1 mask |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq | output | 5 | Interrupt requests per source |

## Verification
Two things can fall in the same clock cycle: a hardware set of a flag, and a clear of that same flag by a write-one or an acknowledge. The bench provokes this in three ways. It drives an overflow together with a write-one to bit 0. It drives an overflow together with an acknowledge of source 0. It arms compare A and then issues a write-one to bit 1 exactly on the tick where the armed channel fires. In every case the flag must read as set on the following cycle, and a clear issued alone afterwards must still take effect.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

    localparam int REG_W    = 8;
    localparam int N_CMP    = 3;
    localparam int N_SRC    = N_CMP + 2;
    localparam int SRC_OVF  = 0;
    localparam int SRC_CMP0 = 1;
    localparam int SRC_CAP  = N_CMP + 1;
    localparam int CAP_BIT  = 5;

    typedef enum logic [0:0] {
        CMP_IDLE  = 1'b0,
        CMP_ARMED = 1'b1
    } cmp_state_e;

    function automatic int src_bit(input int src);
        return (src == SRC_CAP) ? CAP_BIT : src;
    endfunction

    function automatic logic [REG_W-1:0] pack_src(input logic [N_SRC-1:0] v);
        logic [REG_W-1:0] r;
        r = '0;
        for (int i = 0; i < N_SRC; i++) begin
            r[src_bit(i)] = v[i];
        end
        return r;
    endfunction

    function automatic logic [N_SRC-1:0] unpack_src(input logic [REG_W-1:0] w);
        logic [N_SRC-1:0] r;
        for (int i = 0; i < N_SRC; i++) begin
            r[i] = w[src_bit(i)];
        end
        return r;
    endfunction

endpackage

// File: rtl/tmr_irq_cmp_delay.sv
module tmr_irq_cmp_delay
    import tmr_irq_pkg::*;
#(
    parameter int NUM_CMP = N_CMP
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [NUM_CMP-1:0] eq,
    input  logic [NUM_CMP-1:0] frc,
    output logic [NUM_CMP-1:0] fire
);

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_chan
        cmp_state_e st_q;
        cmp_state_e st_d;
        logic       hit;

        assign hit = eq[g] && !frc[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= CMP_IDLE;
            end else begin
                st_q <= st_d;
            end
        end

        always_comb begin
            st_d = st_q;
            unique case (st_q)
                CMP_IDLE: begin
                    if (tick && hit) begin
                        st_d = CMP_ARMED;
                    end
                end
                CMP_ARMED: begin
                    if (tick) begin
                        st_d = hit ? CMP_ARMED : CMP_IDLE;
                    end
                end
                default: st_d = CMP_IDLE;
            endcase
        end

        always_comb begin
            fire[g] = 1'b0;
            unique case (st_q)
                CMP_IDLE:  fire[g] = 1'b0;
                CMP_ARMED: fire[g] = tick;
                default:   fire[g] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/tmr_irq_src_sel.sv
module tmr_irq_src_sel
    import tmr_irq_pkg::*;
(
    input  logic             tick,
    input  logic             ovf,
    input  logic             cap_edge,
    input  logic             cnt_at_top,
    input  logic             cap_is_top,
    input  logic [N_CMP-1:0] cmp_fire,
    output logic [N_SRC-1:0] hw_set
);

    logic cap_evt;

    always_comb begin
        cap_evt = cap_is_top ? cnt_at_top : cap_edge;
    end

    always_comb begin
        hw_set                          = '0;
        hw_set[SRC_OVF]                 = tick && ovf;
        hw_set[SRC_CAP]                 = tick && cap_evt;
        hw_set[SRC_CMP0 +: N_CMP]       = cmp_fire;
    end

endmodule

// File: rtl/tmr_irq_flag_bank.sv
module tmr_irq_flag_bank
    import tmr_irq_pkg::*;
#(
    parameter int NUM_SRC = N_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hw_set,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] flags
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
            end else if (hw_set[g]) begin
                flags[g] <= 1'b1;
            end else if (clr[g]) begin
                flags[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs
    import tmr_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic [N_SRC-1:0] flags,
    output logic [N_SRC-1:0] w1c,
    output logic [N_SRC-1:0] mask,
    output logic [REG_W-1:0] bus_rdata
);

    localparam logic ADDR_FLAG = 1'b0;
    localparam logic ADDR_MASK = 1'b1;

    logic [N_SRC-1:0] wsrc;

    always_comb begin
        wsrc = unpack_src(bus_wdata);
        w1c  = (bus_we && bus_addr == ADDR_FLAG) ? wsrc : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (bus_we && bus_addr == ADDR_MASK) begin
            mask <= wsrc;
        end
    end

    always_comb begin
        bus_rdata = (bus_addr == ADDR_MASK) ? pack_src(mask) : pack_src(flags);
    end

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
    import tmr_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [N_CMP-1:0] cmp_eq,
    input  logic [N_CMP-1:0] cmp_force,
    input  logic             cap_edge,
    input  logic             cnt_at_top,
    input  logic             cap_is_top,
    input  logic             ovf,
    input  logic             gie,
    input  logic [N_SRC-1:0] ack,
    input  logic             bus_we,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic [N_SRC-1:0] irq
);

    logic [N_CMP-1:0] cmp_fire;
    logic [N_SRC-1:0] hw_set;
    logic [N_SRC-1:0] w1c;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] flags_q;
    logic [N_SRC-1:0] clr;

    tmr_irq_cmp_delay #(.NUM_CMP(N_CMP)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .eq    (cmp_eq),
        .frc   (cmp_force),
        .fire  (cmp_fire)
    );

    tmr_irq_src_sel u_sel (
        .tick       (tick),
        .ovf        (ovf),
        .cap_edge   (cap_edge),
        .cnt_at_top (cnt_at_top),
        .cap_is_top (cap_is_top),
        .cmp_fire   (cmp_fire),
        .hw_set     (hw_set)
    );

    assign clr = w1c | ack;

    tmr_irq_flag_bank #(.NUM_SRC(N_SRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (hw_set),
        .clr    (clr),
        .flags  (flags_q)
    );

    tmr_irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flags     (flags_q),
        .w1c       (w1c),
        .mask      (mask_q),
        .bus_rdata (bus_rdata)
    );

    always_comb begin
        irq = flags_q & mask_q & {N_SRC{gie}};
    end

endmodule

// File: rtl/tmr_irq_ctrl_chk.sv
module tmr_irq_ctrl_chk
    import tmr_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             ovf,
    input logic             gie,
    input logic [N_SRC-1:0] ack,
    input logic             bus_we,
    input logic             bus_addr,
    input logic [REG_W-1:0] bus_wdata,
    input logic [REG_W-1:0] bus_rdata,
    input logic [N_SRC-1:0] irq,
    input logic [N_SRC-1:0] flags
);

    logic wr_clr0;
    assign wr_clr0 = bus_we && !bus_addr && bus_wdata[0];

    a_r2_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ovf && !ack[0] && !wr_clr0) |=> flags[0]);

    a_r3_cmp_rises_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(tick));

    a_r5_cap_rises_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[4]) |-> $past(tick));

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[0] && !(tick && ovf)) |=> !flags[0]);

    a_r8_gie_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> (irq == '0));

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[7:6] == 2'b00) && !bus_rdata[4]);

    a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ovf && (ack[0] || wr_clr0)) |=> flags[0]);

endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ovf       (ovf),
    .gie       (gie),
    .ack       (ack),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .flags     (flags_q)
);

// File: tb/tmr_irq_ctrl_tb.sv
module tmr_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic [2:0] cmp_eq = '0;
    logic [2:0] cmp_force = '0;
    logic       cap_edge = 1'b0;
    logic       cnt_at_top = 1'b0;
    logic       cap_is_top = 1'b0;
    logic       ovf = 1'b0;
    logic       gie = 1'b0;
    logic [4:0] ack = '0;
    logic       bus_we = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] rd;
        logic [4:0] irq;
        string      tag;
    } item_t;

    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_eq(cmp_eq),
        .cmp_force(cmp_force), .cap_edge(cap_edge), .cnt_at_top(cnt_at_top),
        .cap_is_top(cap_is_top), .ovf(ovf), .gie(gie), .ack(ack),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // monitor: compares outputs against queued expectations away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            n_chk++;
            if (bus_rdata !== it.rd || irq !== it.irq) begin
                n_fail++;
                $display("FAIL %s: rdata=%02h irq=%05b expected rdata=%02h irq=%05b",
                         it.tag, bus_rdata, irq, it.rd, it.irq);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input logic a, input logic [7:0] rd,
                              input logic [4:0] ir, input string tag);
        item_t it;
        bus_addr = a;
        it.rd = rd; it.irq = ir; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        expect_out(0, 8'h00, 5'b0, "R1 flags after reset");
        expect_out(1, 8'h00, 5'b0, "R1 mask after reset");

        tick = 0; ovf = 1; cyc(); ovf = 0; tick = 1;
        expect_out(0, 8'h00, 5'b0, "R2 overflow without tick");
        ovf = 1; cyc(); ovf = 0;
        expect_out(0, 8'h01, 5'b0, "R2 overflow with tick");

        wr(0, 8'h00);
        expect_out(0, 8'h01, 5'b0, "R6 zero write keeps flag");
        wr(0, 8'h01);
        expect_out(0, 8'h00, 5'b0, "R6 one write clears");

        cmp_eq[0] = 1; cyc(); cmp_eq[0] = 0;
        expect_out(0, 8'h00, 5'b0, "R3 compare A not yet");
        cyc();
        expect_out(0, 8'h02, 5'b0, "R3 compare A one tick later");

        cmp_eq[1] = 1; cyc(); cmp_eq[1] = 0; tick = 0;
        cyc(); cyc();
        expect_out(0, 8'h02, 5'b0, "R3 compare B waits for tick");
        tick = 1; cyc();
        expect_out(0, 8'h06, 5'b0, "R3 compare B on next tick");

        cmp_eq[2] = 1; cmp_force[2] = 1; cyc(); cmp_eq[2] = 0; cmp_force[2] = 0;
        cyc();
        expect_out(0, 8'h06, 5'b0, "R4 forced match discarded");
        cmp_force[2] = 1; cyc(); cmp_force[2] = 0; cyc();
        expect_out(0, 8'h06, 5'b0, "R4 force alone");

        wr(0, 8'hFF);
        expect_out(0, 8'h00, 5'b0, "R6 clear all");
        expect_out(1, 8'h00, 5'b0, "R11 flag write leaves mask");

        cnt_at_top = 1; cyc(); cnt_at_top = 0;
        expect_out(0, 8'h00, 5'b0, "R5 TOP ignored in edge mode");
        cap_edge = 1; cyc(); cap_edge = 0;
        expect_out(0, 8'h20, 5'b0, "R5 capture edge");
        wr(0, 8'h20);
        cap_is_top = 1;
        cap_edge = 1; cyc(); cap_edge = 0;
        expect_out(0, 8'h00, 5'b0, "R5 edge ignored in TOP mode");
        cnt_at_top = 1; cyc(); cnt_at_top = 0;
        expect_out(0, 8'h20, 5'b0, "R5 TOP sets capture flag");
        cap_is_top = 0;

        wr(0, 8'hD0);
        expect_out(0, 8'h20, 5'b0, "R9 reserved flag write");
        wr(1, 8'hFF);
        expect_out(1, 8'h2F, 5'b0, "R9 R11 mask reserved bits");
        expect_out(0, 8'h20, 5'b0, "R11 mask write leaves flags");

        ovf = 1; cyc(); ovf = 0;
        expect_out(0, 8'h21, 5'b00000, "R8 global enable off");
        gie = 1;
        expect_out(0, 8'h21, 5'b10001, "R8 requests on");
        wr(1, 8'h01);
        expect_out(0, 8'h21, 5'b00001, "R8 masked capture");
        wr(1, 8'hFF);

        ack = 5'b10000; cyc(); ack = '0;
        expect_out(0, 8'h01, 5'b00001, "R7 ack capture");

        ovf = 1; bus_we = 1; bus_addr = 0; bus_wdata = 8'h01;
        cyc(); ovf = 0; bus_we = 0; bus_wdata = '0;
        expect_out(0, 8'h01, 5'b00001, "R10 overflow beats write-one");
        ovf = 1; ack = 5'b00001; cyc(); ovf = 0; ack = '0;
        expect_out(0, 8'h01, 5'b00001, "R10 overflow beats ack");
        ack = 5'b00001; cyc(); ack = '0;
        expect_out(0, 8'h00, 5'b00000, "R7 ack overflow");

        cmp_eq[0] = 1; cyc(); cmp_eq[0] = 0;
        wr(0, 8'h02);
        expect_out(0, 8'h02, 5'b00010, "R10 compare fire beats write-one");
        wr(0, 8'h02);
        expect_out(0, 8'h00, 5'b00000, "R6 later clear of compare A");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule